// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Latched Requests

This block gathers one-cycle request pulses from a set of interrupt sources and captures each in its own latched request flag. A per-source enable bit decides whether a captured request may compete for service. The flag itself is never touched by that bit. Among the requests that are both captured and enabled, a fixed priority selector picks the lowest-numbered source. It then offers that source's vector address to the processor through a valid/acknowledge pair, but only while a global enable is on.

Software reaches the block through a small write port that carries a select code and a data word. Through it, software loads the enable bits, clears chosen flags, clears every flag at once, raises chosen flags for testing, and writes the global enable. Accepting a vector removes the chosen source's flag and turns the global enable off, so the handler runs uninterrupted. A return strobe turns the global enable back on. Any request still waiting is then offered straight away.

Top module: `intc_top`

## Requirements
- R1: After reset, all request flags are 0, all enable bits are 0, the global enable is 0 and `irq_valid` is 0.
- R2: A 1 on `src_pulse[i]` sets request flag i at that clock edge, and the flag stays 1 after the pulse ends, until it is cleared by R6 or R8.
- R3: `irq_valid` is 1 exactly when the global enable is 1 and at least one source has both its request flag and its enable bit at 1.
- R4: Writing the enable bits (select 0, data = new enable bits) never changes any request flag. A source whose enable bit is 0 still latches new pulses, and it is offered as soon as its enable bit becomes 1.
- R5: When several sources qualify, the lowest index wins, and `irq_vector` equals `VEC_BASE + 4*index`.
- R6: `irq_ack` while `irq_valid` is 1 clears the offered source's flag and the global enable at the same clock edge. No other flag changes.
- R7: `ret_strobe` sets the global enable to 1. If requests remain, the next one is offered in the cycle after the return.
- R8: A write with select 1 clears every flag whose data bit is 1. A write with select 3 clears all flags, whatever the data.
- R9: A write with select 2 sets every flag whose data bit is 1.
- R10: If a hardware pulse meets a clear (R8) or an acknowledge (R6) on the same flag in the same cycle, the flag ends up 1.
- R11: A write with select 4 loads the global enable from `wr_data[0]`.
- R12: `irq_ack` while `irq_valid` is 0 changes no flag and leaves the global enable as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | N_SRC | One-cycle request pulses, one bit per source |
| wr_en | input | 1 | Software write strobe |
| wr_sel | input | 3 | Write target: 0 enables, 1 clear, 2 set, 3 clear all, 4 global enable |
| wr_data | input | N_SRC | Write data word |
| irq_ack | input | 1 | Processor accepts the offered vector |
| ret_strobe | input | 1 | Processor returns from the handler |
| irq_valid | output | 1 | A vector is being offered |
| irq_vector | output | VEC_W | Address of the offered vector |
| posted_o | output | N_SRC | Current request flags |
| gie_o | output | 1 | Current global enable |

## Verification
The main selection path is swept over every combination of raised flags and enable bits for a four-source configuration. This sweep separates a wrong gating of flags by enables from a wrong priority order or vector arithmetic, and it also covers the all-disabled case. An acknowledge-and-return chain with all sources raised checks the service order and that each acknowledge removes only its own flag. Single-cycle collisions (pulse against clear, pulse against acknowledge) and stray acknowledges show whether an event can be lost or a flag changed without cause.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [2:0] {
    SEL_MASK   = 3'd0,
    SEL_CLR    = 3'd1,
    SEL_SET    = 3'd2,
    SEL_CLRALL = 3'd3,
    SEL_GIE    = 3'd4
  } wr_sel_e;
endpackage

// File: rtl/intc_post_bank.sv
module intc_post_bank #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] hw_post,
  input  logic [N_SRC-1:0] sw_set,
  input  logic [N_SRC-1:0] sw_clr,
  input  logic [N_SRC-1:0] ack_clr,
  output logic [N_SRC-1:0] posted
);
  genvar gi;
  generate
    for (gi = 0; gi < N_SRC; gi++) begin : g_flag
      logic flag_q, flag_d;
      // a new post outranks any clear in the same cycle
      always_comb begin
        flag_d = flag_q & ~sw_clr[gi] & ~ack_clr[gi];
        if (hw_post[gi] || sw_set[gi]) flag_d = 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
      end
      assign posted[gi] = flag_q;
    end
  endgenerate
endmodule

// File: rtl/intc_prio_enc.sv
module intc_prio_enc #(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] req,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [N_SRC-1:0] win
);
  always_comb begin
    idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
    any = |req;
    win = any ? (N_SRC'(1) << idx) : '0;
  end
endmodule

// File: rtl/intc_gie_ctrl.sv
module intc_gie_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic ret,
  input  logic sw_wr,
  input  logic sw_val,
  output logic gie
);
  logic gie_q, gie_d;
  always_comb begin
    gie_d = gie_q;
    if (take)       gie_d = 1'b0;
    else if (ret)   gie_d = 1'b1;
    else if (sw_wr) gie_d = sw_val;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gie_q <= 1'b0;
    else        gie_q <= gie_d;
  end
  assign gie = gie_q;
endmodule

// File: rtl/intc_top.sv
module intc_top #(
  parameter int N_SRC = 8,
  parameter int VEC_W = 16,
  parameter logic [VEC_W-1:0] VEC_BASE = 16'h0040
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_pulse,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [N_SRC-1:0] wr_data,
  input  logic             irq_ack,
  input  logic             ret_strobe,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vector,
  output logic [N_SRC-1:0] posted_o,
  output logic             gie_o
);
  import intc_pkg::*;
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  wr_sel_e          sel;
  logic [N_SRC-1:0] mask_q, mask_d;
  logic [N_SRC-1:0] sw_set, sw_clr, ack_clr, pending, win;
  logic [IDX_W-1:0] win_idx;
  logic             any_pend, take, gie;

  assign sel = wr_sel_e'(wr_sel);

  // software write decode
  always_comb begin
    sw_set = '0;
    sw_clr = '0;
    mask_d = mask_q;
    if (wr_en) begin
      case (sel)
        SEL_MASK:   mask_d = wr_data;
        SEL_CLR:    sw_clr = wr_data;
        SEL_SET:    sw_set = wr_data;
        SEL_CLRALL: sw_clr = '1;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  intc_post_bank #(.N_SRC(N_SRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .hw_post(src_pulse), .sw_set(sw_set),
    .sw_clr(sw_clr), .ack_clr(ack_clr), .posted(posted_o)
  );

  assign pending = posted_o & mask_q;

  intc_prio_enc #(.N_SRC(N_SRC)) u_enc (
    .req(pending), .any(any_pend), .idx(win_idx), .win(win)
  );

  assign irq_valid  = gie & any_pend;
  assign take       = irq_valid & irq_ack;
  assign ack_clr    = take ? win : '0;
  assign irq_vector = VEC_BASE + (VEC_W'(win_idx) << 2);

  intc_gie_ctrl u_gie (
    .clk(clk), .rst_n(rst_n), .take(take), .ret(ret_strobe),
    .sw_wr(wr_en && (sel == SEL_GIE)), .sw_val(wr_data[0]), .gie(gie)
  );

  assign gie_o = gie;
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int N_SRC = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] src_pulse,
  input logic             wr_en,
  input logic [2:0]       wr_sel,
  input logic             irq_ack,
  input logic             ret_strobe,
  input logic             irq_valid,
  input logic [N_SRC-1:0] posted_o,
  input logic [N_SRC-1:0] mask_q,
  input logic             gie_o
);
  // R2
  post_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_pulse) |=> ((posted_o & $past(src_pulse)) == $past(src_pulse)));
  // R3
  valid_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (gie_o && |(posted_o & mask_q)));
  // R4
  mask_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0 && !irq_ack) |=>
      ((posted_o & $past(posted_o)) == $past(posted_o)));
  // R6
  ack_drops_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ack) |=> !gie_o);
  // R7
  ret_sets_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_strobe && !(irq_valid && irq_ack)) |=> gie_o);
  // R8
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd3 && !(|src_pulse)) |=> (posted_o == '0));
endmodule

bind intc_top intc_checker #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .wr_en(wr_en),
  .wr_sel(wr_sel), .irq_ack(irq_ack), .ret_strobe(ret_strobe),
  .irq_valid(irq_valid), .posted_o(posted_o), .mask_q(mask_q), .gie_o(gie_o)
);

// File: tb/tb_intc_top.sv
module tb_intc_top;
  localparam int N = 4;
  localparam int VW = 12;
  localparam logic [VW-1:0] BASE = 12'h100;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] src_pulse;
  logic wr_en;
  logic [2:0] wr_sel;
  logic [N-1:0] wr_data;
  logic irq_ack, ret_strobe;
  logic irq_valid;
  logic [VW-1:0] irq_vector;
  logic [N-1:0] posted_o;
  logic gie_o;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  intc_top #(.N_SRC(N), .VEC_W(VW), .VEC_BASE(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .irq_ack(irq_ack),
    .ret_strobe(ret_strobe), .irq_valid(irq_valid), .irq_vector(irq_vector),
    .posted_o(posted_o), .gie_o(gie_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(input logic [N-1:0] p);
    @(negedge clk);
    src_pulse = p;
    @(negedge clk);
    src_pulse = '0;
  endtask

  function automatic int lowest(input logic [N-1:0] v);
    for (int i = N - 1; i >= 0; i--) if (v[i]) lowest = i;
    if (v == '0) lowest = 0;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; src_pulse = '0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    irq_ack = 1'b0; ret_strobe = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(posted_o == '0, "R1 posted", posted_o, 0);
    chk(gie_o == 1'b0, "R1 gie", gie_o, 0);
    chk(irq_valid == 1'b0, "R1 valid", irq_valid, 0);
    wr(3'd4, 4'b0001);
    wr(3'd2, 4'hF);
    chk(irq_valid == 1'b0, "R1 mask reset 0", irq_valid, 0);

    // R2 hardware pulse latches and holds
    wr(3'd3, '0);
    pulse(4'b0100);
    repeat (3) @(negedge clk);
    chk(posted_o == 4'b0100, "R2 hold", posted_o, 4'b0100);

    // R3/R5 exhaustive sweep over flags x enables, R9 set path
    for (int p = 0; p < 16; p++) begin
      for (int m = 0; m < 16; m++) begin
        wr(3'd3, '0);
        wr(3'd2, N'(p));
        wr(3'd0, N'(m));
        chk(posted_o == N'(p), "R9 set", posted_o, p);
        chk(irq_valid == ((p & m) != 0), "R3 valid", irq_valid, ((p & m) != 0));
        if ((p & m) != 0)
          chk(irq_vector == BASE + VW'(4 * lowest(N'(p & m))), "R5 vector",
              irq_vector, BASE + VW'(4 * lowest(N'(p & m))));
      end
    end

    // R11 global enable write
    wr(3'd3, '0); wr(3'd0, 4'hF); wr(3'd2, 4'b0010);
    wr(3'd4, 4'b0000);
    chk(irq_valid == 1'b0 && gie_o == 1'b0, "R11 off", irq_valid, 0);
    // R12 stray acknowledge
    @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk(posted_o == 4'b0010, "R12 flags", posted_o, 4'b0010);
    chk(gie_o == 1'b0, "R12 gie", gie_o, 0);
    wr(3'd4, 4'b0001);
    chk(irq_valid == 1'b1 && gie_o == 1'b1, "R11 on", irq_valid, 1);

    // R4 masked source still latches and keeps its flag
    wr(3'd3, '0); wr(3'd0, 4'b0000);
    pulse(4'b1000);
    chk(irq_valid == 1'b0 && posted_o == 4'b1000, "R4 masked", posted_o, 4'b1000);
    wr(3'd0, 4'b0001);
    chk(posted_o == 4'b1000, "R4 kept", posted_o, 4'b1000);
    wr(3'd0, 4'b1000);
    chk(irq_valid == 1'b1 && irq_vector == BASE + 12'd12, "R4 unmask", irq_vector, BASE + 12'd12);

    // R6/R7 service chain
    wr(3'd3, '0); wr(3'd0, 4'hF); wr(3'd2, 4'hF);
    for (int k = 0; k < N; k++) begin
      chk(irq_valid && irq_vector == BASE + VW'(4 * k), "R7 next vector",
          irq_vector, BASE + VW'(4 * k));
      @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
      chk(posted_o == N'(4'hF << (k + 1)), "R6 flag", posted_o, N'(4'hF << (k + 1)));
      chk(gie_o == 1'b0 && irq_valid == 1'b0, "R6 gie", gie_o, 0);
      @(negedge clk); ret_strobe = 1'b1; @(negedge clk); ret_strobe = 1'b0;
      chk(gie_o == 1'b1, "R7 gie", gie_o, 1);
    end
    chk(irq_valid == 1'b0, "R7 drained", irq_valid, 0);

    // R8 selective clear and clear-all
    wr(3'd2, 4'b1011);
    wr(3'd1, 4'b0011);
    chk(posted_o == 4'b1000, "R8 clear", posted_o, 4'b1000);
    wr(3'd2, 4'b0111);
    wr(3'd3, 4'b0000);
    chk(posted_o == 4'b0000, "R8 clear all", posted_o, 0);

    // R10 post beats clear
    @(negedge clk);
    src_pulse = 4'b0100; wr_en = 1'b1; wr_sel = 3'd1; wr_data = 4'b0110;
    @(negedge clk);
    src_pulse = '0; wr_en = 1'b0; wr_data = '0;
    chk(posted_o == 4'b0100, "R10 vs clear", posted_o, 4'b0100);
    // R10 post beats acknowledge
    wr(3'd3, '0); wr(3'd2, 4'b0001);
    @(negedge clk); irq_ack = 1'b1; src_pulse = 4'b0001;
    @(negedge clk); irq_ack = 1'b0; src_pulse = '0;
    chk(posted_o == 4'b0001 && gie_o == 1'b0, "R10 vs ack", posted_o, 4'b0001);

    finish_run();
  end
endmodule